// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block derives the serial clock of an SPI controller from the core clock. A packed prescale field sets the divide ratio. A one-bit mode input chooses between two ways of reading that field. The extended reading multiplies a 4-bit mantissa by a power of two. The exponent's three bits are split: two of them sit above a gap in the field and one sits below it. The legacy reading gives only even ratios, from an offset 5-bit value. Computing the best field value for a target rate belongs to software and is not done here.

While the run input is high, the block produces a registered serial-clock phase. Each period starts with its high phase. The block also produces a one-cycle strobe that marks every cycle in which the phase has just changed, and a shift engine uses both signals. The ratio is captured only at the start of a period, so software may rewrite the field while a transfer is running without producing a shortened or stretched half-period.

Top module: `sclk_prescaler`

## Requirements
- R1: During and after synchronous reset (rst_n low), sclk_o and tick_o are 0.
- R2: In the cycle after a clock edge that samples run_i low, sclk_o is 0. It stays 0 with tick_o 0 for as long as run_i stays low.
- R3: At the first edge that samples run_i high after an idle cycle, a period starts: in the next cycle sclk_o is 1 and tick_o is 1.
- R4: tick_o is 1 in exactly those cycles where sclk_o differs from its value in the previous cycle.
- R5: In extended mode (mode_ext_i = 1) the ratio is M × 2^E, where M = field_i[3:0] and E = {field_i[7], field_i[6], field_i[4]}. field_i[5] has no effect.
- R6: In legacy mode (mode_ext_i = 0) with field_i[4] = 1, the ratio is 2 × field_i[3:0]. field_i[7:5] have no effect.
- R7: A decoded ratio below 4 is raised to 4. This covers extended products under 4, and legacy values with field_i[4] = 0 or field_i[3:0] < 2.
- R8: The high phase lasts ceil(ratio/2) core cycles and the low phase lasts floor(ratio/2), so the high phase gets the extra cycle of an odd ratio.
- R9: A change to field_i or mode_ext_i during a period takes effect only at the next rising boundary of sclk_o.
- R10: The largest ratio is 1920 (field 0xDF in extended mode), which gives a half-period of 960 cycles. No half-period is longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | High to generate the serial clock, low to hold it idle low |
| mode_ext_i | input | 1 | 1 = mantissa/exponent decoding, 0 = legacy even-ratio decoding |
| field_i | input | 8 | Packed prescale field |
| sclk_o | output | 1 | Registered serial-clock phase |
| tick_o | output | 1 | One-cycle strobe in each cycle where sclk_o has just changed |

## Verification
Some properties hold on every cycle, and the assertions check those: the strobe coincides exactly with phase changes, the clock goes idle low when run drops, a period starts at once when run rises, no half-period exceeds 960 cycles, and within each period the high phase equals the low phase or exceeds it by one cycle. Only the bench's scenarios can show that the measured period equals the arithmetic ratio of every field value in both modes, including the clamped values and the ignored bits. The same applies to a mid-period field rewrite, which must leave the current period untouched.

// File: rtl/sclk_presc_pkg.sv
// Shared constants for the serial-clock prescaler.
// Assumes the fixed 8-bit field layout: mantissa in [3:0], exponent bit 0 in [4], exponent bits 2:1 in [7:6].
package sclk_presc_pkg;
    localparam int FIELD_W   = 8;
    localparam int MANT_W    = 4;
    localparam int EXP_W     = 3;
    localparam int MAX_SHIFT = (1 << EXP_W) - 1;
    localparam int RATIO_W   = MANT_W + MAX_SHIFT;
    localparam int HALF_W    = RATIO_W - 1;
    localparam int MAX_RATIO = ((1 << MANT_W) - 1) << MAX_SHIFT;
    localparam int MIN_RATIO = 4;

    typedef enum logic {
        DEC_LEGACY   = 1'b0,
        DEC_EXTENDED = 1'b1
    } dec_mode_e;
endpackage

// File: rtl/sclk_presc_decode.sv
// Field decoder: turns the packed prescale field into a divide ratio.
// Assumes field layout from sclk_presc_pkg; the result is clamped to MIN_RATIO.
module sclk_presc_decode
    import sclk_presc_pkg::*;
#(
    parameter bit LEGACY_EN = 1'b1
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               mode_ext_i,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [MANT_W-1:0]  mant;
    logic [EXP_W-1:0]   expo;
    logic [RATIO_W-1:0] ext_ratio;
    logic [RATIO_W-1:0] raw_ratio;
    logic               field_unused;

    assign mant         = field_i[3:0];
    assign expo         = {field_i[7:6], field_i[4]};
    assign field_unused = field_i[5];

    // Extended reading: mantissa shifted left by the scattered exponent.
    always_comb ext_ratio = RATIO_W'(mant) << expo;

    generate
        if (LEGACY_EN) begin : g_legacy
            logic [RATIO_W-1:0] leg_ratio;
            // Legacy reading: offset value 0x10 + ratio/2, so ratio = 2 * low nibble.
            always_comb leg_ratio = field_i[4] ? RATIO_W'({field_i[3:0], 1'b0}) : '0;
            // Mode select between the two readings.
            always_comb raw_ratio = (dec_mode_e'(mode_ext_i) == DEC_EXTENDED) ? ext_ratio : leg_ratio;
        end else begin : g_ext_only
            logic mode_unused;
            assign mode_unused = mode_ext_i;
            // Only the extended reading exists in this variant.
            always_comb raw_ratio = ext_ratio;
        end
    endgenerate

    // Clamp to the smallest usable ratio.
    always_comb ratio_o = (raw_ratio < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : raw_ratio;
endmodule

// File: rtl/sclk_presc_split.sv
// Half-period splitter: divides a ratio into high and low phase lengths.
// Assumes ratio_i >= MIN_RATIO; the high phase takes the odd cycle.
module sclk_presc_split
    import sclk_presc_pkg::*;
(
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [HALF_W-1:0]  hi_len_o,
    output logic [HALF_W-1:0]  lo_len_o
);
    logic [RATIO_W:0] rounded;

    // Round up for the high phase, round down for the low phase.
    always_comb begin
        rounded  = {1'b0, ratio_i} + (RATIO_W+1)'(1);
        hi_len_o = HALF_W'(rounded >> 1);
        lo_len_o = HALF_W'(ratio_i >> 1);
    end
endmodule

// File: rtl/sclk_presc_phase.sv
// Phase generator: counts core cycles per half-period and toggles the serial clock.
// Assumes phase lengths >= 2; new lengths are captured only when a high phase begins.
module sclk_presc_phase
    import sclk_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HALF_W-1:0] next_hi_i,
    input  logic [HALF_W-1:0] next_lo_i,
    output logic              sclk_o,
    output logic              tick_o
);
    logic              sclk_q;
    logic              tick_q;
    logic              started_q;
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] hi_q;
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] last_cnt;
    logic              half_done;

    // Last count value of the current half-period.
    always_comb begin
        last_cnt  = (sclk_q ? hi_q : lo_q) - HALF_W'(1);
        half_done = (cnt_q == last_cnt);
    end

    // Phase counter, clock phase and change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            tick_q    <= 1'b0;
            started_q <= 1'b0;
            cnt_q     <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
        end else if (!run_i) begin
            sclk_q    <= 1'b0;
            tick_q    <= sclk_q;
            started_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!started_q) begin
            sclk_q    <= 1'b1;
            tick_q    <= 1'b1;
            started_q <= 1'b1;
            cnt_q     <= '0;
            hi_q      <= next_hi_i;
            lo_q      <= next_lo_i;
        end else if (half_done) begin
            sclk_q <= ~sclk_q;
            tick_q <= 1'b1;
            cnt_q  <= '0;
            if (!sclk_q) begin
                hi_q <= next_hi_i;
                lo_q <= next_lo_i;
            end
        end else begin
            tick_q <= 1'b0;
            cnt_q  <= cnt_q + HALF_W'(1);
        end
    end

    assign sclk_o = sclk_q;
    assign tick_o = tick_q;
endmodule

// File: rtl/sclk_prescaler.sv
// Serial-clock prescaler top: decode field, split into phases, generate the clock.
// Assumes field_i and mode_ext_i are synchronous to clk.
module sclk_prescaler
    import sclk_presc_pkg::*;
#(
    parameter bit LEGACY_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               mode_ext_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               sclk_o,
    output logic               tick_o
);
    logic [RATIO_W-1:0] ratio;
    logic [HALF_W-1:0]  hi_len;
    logic [HALF_W-1:0]  lo_len;

    sclk_presc_decode #(.LEGACY_EN(LEGACY_EN)) u_decode (
        .field_i    (field_i),
        .mode_ext_i (mode_ext_i),
        .ratio_o    (ratio)
    );

    sclk_presc_split u_split (
        .ratio_i  (ratio),
        .hi_len_o (hi_len),
        .lo_len_o (lo_len)
    );

    sclk_presc_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .next_hi_i (hi_len),
        .next_lo_i (lo_len),
        .sclk_o    (sclk_o),
        .tick_o    (tick_o)
    );
endmodule

// File: rtl/sclk_prescaler_chk.sv
// Checker for sclk_prescaler: strobe/phase consistency, idle, start and half-period bounds.
// Assumes it observes only the top-level ports.
module sclk_prescaler_chk
    import sclk_presc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic run_i,
    input logic sclk_o,
    input logic tick_o
);
    localparam int MAX_HALF = MAX_RATIO / 2;

    logic             pv_q;
    logic             prev_sclk_q;
    logic             prev_run_q;
    logic [RATIO_W:0] len_q;
    logic [RATIO_W:0] hi_len_q;
    logic             hi_ok_q;

    // History registers and phase-length measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q        <= 1'b0;
            prev_sclk_q <= 1'b0;
            prev_run_q  <= 1'b0;
            len_q       <= '0;
            hi_len_q    <= '0;
            hi_ok_q     <= 1'b0;
        end else begin
            pv_q        <= 1'b1;
            prev_sclk_q <= sclk_o;
            prev_run_q  <= run_i;
            if (!run_i) begin
                len_q   <= '0;
                hi_ok_q <= 1'b0;
            end else if (tick_o) begin
                len_q <= (RATIO_W+1)'(1);
                if (!sclk_o) begin
                    hi_len_q <= len_q;
                    hi_ok_q  <= (len_q != '0);
                end
            end else begin
                len_q <= len_q + (RATIO_W+1)'(1);
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sclk_o && !tick_o));

    a_r4_tick_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q |-> (tick_o == (sclk_o != prev_sclk_q)));

    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_o);

    a_r3_start_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && run_i && !prev_run_q) |=> (sclk_o && tick_o));

    a_r10_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= (RATIO_W+1)'(MAX_HALF));

    a_r8_phase_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_o && sclk_o && hi_ok_q) |->
            ((len_q <= hi_len_q) && (hi_len_q <= len_q + (RATIO_W+1)'(1))));

    a_r7_min_half: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_o && sclk_o && hi_ok_q) |-> (len_q >= (RATIO_W+1)'(MIN_RATIO / 2)));
endmodule

bind sclk_prescaler sclk_prescaler_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .sclk_o (sclk_o),
    .tick_o (tick_o)
);

// File: tb/test_sclk_prescaler.sv
module test_sclk_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       mode_ext_i = 1'b1;
    logic [7:0] field_i = 8'h00;
    logic       sclk_o;
    logic       tick_o;

    int total = 0;
    int fails = 0;
    int tick_err = 0;
    logic prev_sclk = 1'b0;

    always #4 clk = ~clk;

    sclk_prescaler i_sclk_prescaler (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .mode_ext_i(mode_ext_i),
        .field_i(field_i), .sclk_o(sclk_o), .tick_o(tick_o)
    );

    // R4 monitor: strobe must match phase change at every sample.
    always @(negedge clk) begin
        if (rst_n && (tick_o != (sclk_o != prev_sclk))) tick_err++;
        prev_sclk = sclk_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int raw_ratio(input logic m, input logic [7:0] f);
        if (m) return int'(f[3:0]) * (1 << int'({f[7], f[6], f[4]}));
        return f[4] ? 2 * int'(f[3:0]) : 0;
    endfunction

    function automatic int exp_ratio(input logic m, input logic [7:0] f);
        int r = raw_ratio(m, f);
        return (r < 4) ? 4 : r;
    endfunction

    task automatic count_high(output int n);
        n = 0;
        while (sclk_o == 1'b1 && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (sclk_o == 1'b0 && n < 5000) begin n++; @(negedge clk); end
    endtask

    // Start one period from idle and measure both phases.
    task automatic measure(input logic m, input logic [7:0] f, output int hi, output int lo, output int st);
        run_i = 1'b0;
        @(negedge clk); @(negedge clk);
        mode_ext_i = m; field_i = f; run_i = 1'b1;
        @(negedge clk);
        st = (sclk_o && tick_o) ? 1 : 0;
        count_high(hi);
        count_low(lo);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int hi, lo, st, r, start_bad;
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!sclk_o && !tick_o, "R1 reset outputs", {sclk_o, tick_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sclk_o && !tick_o, "R1 after reset", {sclk_o, tick_o}, 0);

        // R5/R7/R8/R10: all extended field values
        start_bad = 0;
        for (int v = 0; v < 256; v++) begin
            measure(1'b1, 8'(v), hi, lo, st);
            r = exp_ratio(1'b1, 8'(v));
            if (st == 0) start_bad++;
            tag = (raw_ratio(1'b1, 8'(v)) < 4) ? "R7 ext clamp high" : "R5 R8 ext high";
            check(hi == (r + 1) / 2, tag, hi, (r + 1) / 2);
            tag = (raw_ratio(1'b1, 8'(v)) < 4) ? "R7 ext clamp low" : "R5 R8 ext low";
            check(lo == r / 2, tag, lo, r / 2);
            if (v == 8'hDF) check(hi + lo == 1920, "R10 max ratio", hi + lo, 1920);
        end
        // R6/R7/R8: all legacy field values
        for (int v = 0; v < 256; v++) begin
            measure(1'b0, 8'(v), hi, lo, st);
            r = exp_ratio(1'b0, 8'(v));
            if (st == 0) start_bad++;
            tag = (raw_ratio(1'b0, 8'(v)) < 4) ? "R7 legacy clamp" : "R6 R8 legacy period";
            check(hi == (r + 1) / 2 && lo == r / 2, tag, hi + lo, r);
        end
        check(start_bad == 0, "R3 start strobe", start_bad, 0);

        // R9: rewrite field mid-period, old ratio 8 finishes, new ratio 12 follows
        run_i = 1'b0;
        @(negedge clk); @(negedge clk);
        mode_ext_i = 1'b1; field_i = 8'h08; run_i = 1'b1;
        @(negedge clk);
        field_i = 8'h0C;
        count_high(hi); count_low(lo);
        check(hi == 4 && lo == 4, "R9 current period kept", hi + lo, 8);
        count_high(hi); count_low(lo);
        check(hi == 6 && lo == 6, "R9 new ratio at boundary", hi + lo, 12);
        mode_ext_i = 1'b0; field_i = 8'h1F;
        count_high(hi); count_low(lo);
        check(hi == 6 && lo == 6, "R9 mode change deferred", hi + lo, 12);
        count_high(hi); count_low(lo);
        check(hi == 15 && lo == 15, "R9 mode change applied", hi + lo, 30);

        // R2: drop run mid high phase
        mode_ext_i = 1'b1; field_i = 8'h0F;
        repeat (3) @(negedge clk);
        check(sclk_o == 1'b1, "R2 running high before drop", sclk_o, 1);
        run_i = 1'b0;
        @(negedge clk);
        check(sclk_o == 1'b0, "R2 low after drop", sclk_o, 0);
        st = 0;
        repeat (6) begin
            @(negedge clk);
            if (sclk_o || tick_o) st++;
        end
        check(st == 0, "R2 stays idle", st, 0);

        check(tick_err == 0, "R4 strobe matches change", tick_err, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule